// File: doc/BRIEF.md
# Banked UART Register and FIFO Controller

This block is the host-facing half of a 16550-compatible serial port. A byte-wide register bus, addressed by a 3-bit offset with separate read and write strobes, reaches the line control, FIFO control, interrupt enable, interrupt identification and line status registers. It also reaches a pair of divisor bytes, which share offsets with the data and interrupt enable registers. Behind the bus sit a transmit queue and a receive queue of parameterised depth (16 by default). The serializer drains the transmit queue through a pop interface and fills the receive queue through a push interface. It also reports, through a busy input, whether a character is still shifting out.

Software primes the transmitter by writing bytes. Once the serializer has taken the last queued byte, a transmit-empty event is latched. That event is the only point at which software learns it may refill the queue: no status bit shows a partly drained transmit queue. Received bytes raise a data-available cause once their count reaches a level chosen by a 2-bit trigger field. A single interrupt output is the OR of all enabled causes, and the identification register names the highest-priority one.

Top module: `uart_regfifo_ctrl`

## Requirements
- R1: With queues enabled, each queue holds 16 bytes in first-in first-out order. A data write to a full transmit queue is dropped.
- R2: Line control bit 7 (divisor access) set remaps offset 0 to the divisor low byte and offset 1 to the divisor high byte, for reads and writes. While it is set, data writes do not enter the transmit queue and interrupt enable writes have no effect. With it clear, offset 0 is the data port and offset 1 is the interrupt enable register.
- R3: Line status bit 5 is 1 exactly when the transmit queue is empty: 1 after reset and 0 as soon as one byte is written. Bit 6 is 1 when the transmit queue is empty and the busy input is low.
- R4: The transmit-empty cause becomes pending only when the serializer pops the last byte and leaves the transmit queue empty. Setting interrupt enable bit 1 with nothing ever written raises no interrupt.
- R5: A pending transmit-empty cause is cleared by a read of the identification register (offset 2) that reports it, or by a data write.
- R6: A FIFO control write (offset 2) sets the queue enable from bit 0 and the trigger code from bits 7:6. Bit 1 empties the receive queue and bit 2 empties the transmit queue. The reset bits are not stored, so writing 0x07 leaves both queues empty and working.
- R7: Trigger code 00, 01, 10, 11 raises data-available when the receive count reaches 1, 4, 8, 14, gated by interrupt enable bit 0.
- R8: The identification register reads 0x01 with no enabled cause pending, 0x04 for data-available and 0x02 for transmit-empty, with bits 7:6 set to 11 while queues are enabled. Data-available outranks transmit-empty.
- R9: The interrupt output is high exactly when some enabled cause is pending.
- R10: A push into a full receive queue is dropped and sets line status bit 1 (overrun), which a line status read (offset 5) clears.
- R11: With queues disabled (the reset state), each queue holds one byte and the receive trigger is 1. Changing the enable bit empties both queues.
- R12: Line status bit 0 is 1 while the receive queue holds data. A data read (offset 0) returns the oldest received byte and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_valid | output | 1 | Transmit queue is not empty |
| tx_pop | input | 1 | Serializer takes tx_data |
| tx_busy | input | 1 | Serializer is shifting a character |
| rx_data | input | 8 | Received byte |
| rx_push | input | 1 | Store rx_data in the receive queue |

## Verification
Read data is combinational from registered state, so the value of a read is due in the same cycle as the strobe. The bench samples it one nanosecond after driving the strobe on the falling edge, before the edge that applies the read's side effects. Writes, pushes and pops take effect at the following rising edge. Line status, tx_valid, tx_data, identification and irq all reflect that edge at once, with no further register stage, so every check runs after the access task has returned on the next falling edge. The trigger table and the priority tests depend on this single-edge latency to tell a count one short of the level from a count that reaches it.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_IEN  = 3'd1;
   localparam logic [2:0] OFS_IDENT = 3'd2;
   localparam logic [2:0] OFS_LCTL = 3'd3;
   localparam logic [2:0] OFS_LSTAT = 3'd5;

   typedef enum logic [2:0] {
      CAUSE_NONE = 3'b000,
      CAUSE_TXE  = 3'b001,
      CAUSE_RXAV = 3'b010
   } cause_e;

   localparam int LCTL_DIVACC_BIT = 7;
   localparam int FCTL_EN_BIT     = 0;
   localparam int FCTL_RXCLR_BIT  = 1;
   localparam int FCTL_TXCLR_BIT  = 2;

endpackage

// File: rtl/sync_fifo_buf.sv
module sync_fifo_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << AW));

   if (DEPTH < 1) begin : g_bad_depth
      $error("sync_fifo_buf: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   if (POW2) begin : g_wrap_pow2
      always_comb begin
         wr_nxt = wr_ptr_q + 1'b1;
         rd_nxt = rd_ptr_q + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_comb begin
         wr_nxt = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         rd_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem_q[wr_ptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_nxt;
         if (pop)  rd_ptr_q <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem_q[rd_ptr_q];
   assign count = cnt_q;

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr) |-> (cnt_q < CNT_W'(DEPTH)));
   p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> (cnt_q != '0));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_regs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_hit,
   input  logic       en_rx,
   input  logic       en_txe,
   input  logic       fifo_en,
   input  logic       tx_drain,
   input  logic       tx_wr,
   input  logic       ident_rd,
   output logic [7:0] ident,
   output logic       irq
);
   logic   txe_pend_q;
   logic   rx_act, txe_act;
   cause_e cause;

   assign rx_act  = rx_hit && en_rx;
   assign txe_act = txe_pend_q && en_txe;

   always_comb begin
      if (rx_act)       cause = CAUSE_RXAV;
      else if (txe_act) cause = CAUSE_TXE;
      else              cause = CAUSE_NONE;
   end

   // Drain wins over a clear arriving in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         txe_pend_q <= 1'b0;
      else if (tx_drain)
         txe_pend_q <= 1'b1;
      else if (tx_wr || (ident_rd && cause == CAUSE_TXE))
         txe_pend_q <= 1'b0;
   end

   assign ident = {fifo_en, fifo_en, 2'b00, cause, (cause == CAUSE_NONE)};
   assign irq   = rx_act || txe_act;

   p_txe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drain |=> txe_pend_q);
   p_txe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!txe_pend_q && !tx_drain) |=> !txe_pend_q);
   p_txe_wr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !tx_drain) |=> !txe_pend_q);
   p_rx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_hit && en_rx) |-> (ident[3:1] == 3'b010));
   p_irq_ident_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !ident[0]);

endmodule

// File: rtl/uart_regfifo_ctrl.sv
module uart_regfifo_ctrl
   import uart_regs_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TRIG_LVL0  = 1,
   parameter int TRIG_LVL1  = 4,
   parameter int TRIG_LVL2  = 8,
   parameter int TRIG_LVL3  = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       bus_wr,
   input  logic       bus_rd,
   output logic [7:0] bus_rdata,
   output logic       irq,
   output logic [7:0] tx_data,
   output logic       tx_valid,
   input  logic       tx_pop,
   input  logic       tx_busy,
   input  logic [7:0] rx_data,
   input  logic       rx_push
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
   localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(FIFO_DEPTH);
   localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_regfifo_ctrl: FIFO_DEPTH must be at least 2");
   end
   if (TRIG_LVL0 < 1 || TRIG_LVL3 > FIFO_DEPTH || TRIG_LVL0 > TRIG_LVL1 ||
       TRIG_LVL1 > TRIG_LVL2 || TRIG_LVL2 > TRIG_LVL3) begin : g_bad_trig
      $error("uart_regfifo_ctrl: trigger levels must rise within 1..FIFO_DEPTH");
   end

   logic [7:0]       lctl_q, div_lo_q, div_hi_q;
   logic [1:0]       ien_q, trig_q;
   logic             fifo_en_q, ovr_q;
   logic             divacc;
   logic             data_wr, data_rd, fctl_wr, ident_rd, lstat_rd;
   logic             tx_clr, rx_clr, tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
   logic             tx_full, rx_full, tx_drain, rx_hit;
   logic [CNT_W-1:0] tx_cnt, rx_cnt, cap, trig_lvl;
   logic [7:0]       rx_head, ident, lstat;

   assign divacc   = lctl_q[LCTL_DIVACC_BIT];
   assign data_wr  = bus_wr && bus_addr == OFS_DATA && !divacc;
   assign data_rd  = bus_rd && bus_addr == OFS_DATA && !divacc;
   assign fctl_wr  = bus_wr && bus_addr == OFS_IDENT;
   assign ident_rd = bus_rd && bus_addr == OFS_IDENT;
   assign lstat_rd = bus_rd && bus_addr == OFS_LSTAT;

   // Queue capacity: full depth when enabled, single holding byte otherwise.
   assign cap     = fifo_en_q ? CAP_FULL : CAP_ONE;
   assign tx_full = tx_cnt >= cap;
   assign rx_full = rx_cnt >= cap;

   logic en_change;
   assign en_change = bus_wdata[FCTL_EN_BIT] != fifo_en_q;
   assign tx_clr    = fctl_wr && (bus_wdata[FCTL_TXCLR_BIT] || en_change);
   assign rx_clr    = fctl_wr && (bus_wdata[FCTL_RXCLR_BIT] || en_change);

   assign tx_push_ok = data_wr && !tx_full;
   assign tx_pop_ok  = tx_pop && tx_cnt != '0;
   assign rx_push_ok = rx_push && !rx_full;
   assign rx_pop_ok  = data_rd && rx_cnt != '0;
   assign tx_drain   = tx_pop_ok && tx_cnt == CAP_ONE && !tx_push_ok && !tx_clr;

   always_comb begin
      case (trig_q)
         2'd0:    trig_lvl = CNT_W'(TRIG_LVL0);
         2'd1:    trig_lvl = CNT_W'(TRIG_LVL1);
         2'd2:    trig_lvl = CNT_W'(TRIG_LVL2);
         default: trig_lvl = CNT_W'(TRIG_LVL3);
      endcase
   end
   assign rx_hit = rx_cnt >= (fifo_en_q ? trig_lvl : CAP_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctl_q    <= '0;
         div_lo_q  <= '0;
         div_hi_q  <= '0;
         ien_q     <= '0;
         trig_q    <= '0;
         fifo_en_q <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFS_DATA:  if (divacc) div_lo_q <= bus_wdata;
            OFS_IEN:   if (divacc) div_hi_q <= bus_wdata;
                       else        ien_q    <= bus_wdata[1:0];
            OFS_IDENT: begin
               fifo_en_q <= bus_wdata[FCTL_EN_BIT];
               trig_q    <= bus_wdata[7:6];
            end
            OFS_LCTL:  lctl_q <= bus_wdata;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ovr_q <= 1'b0;
      else if (rx_push && rx_full && !rx_clr) ovr_q <= 1'b1;
      else if (lstat_rd)                 ovr_q <= 1'b0;
   end

   sync_fifo_buf #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push_ok), .pop(tx_pop_ok),
      .din(bus_wdata), .dout(tx_data), .count(tx_cnt)
   );

   sync_fifo_buf #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push_ok), .pop(rx_pop_ok),
      .din(rx_data), .dout(rx_head), .count(rx_cnt)
   );

   uart_irq_ident u_irq (
      .clk(clk), .rst_n(rst_n),
      .rx_hit(rx_hit), .en_rx(ien_q[0]), .en_txe(ien_q[1]),
      .fifo_en(fifo_en_q), .tx_drain(tx_drain), .tx_wr(data_wr),
      .ident_rd(ident_rd), .ident(ident), .irq(irq)
   );

   assign tx_valid = tx_cnt != '0;
   assign lstat = {1'b0, (tx_cnt == '0) && !tx_busy, (tx_cnt == '0),
                   3'b000, ovr_q, (rx_cnt != '0)};

   always_comb begin
      case (bus_addr)
         OFS_DATA:  bus_rdata = divacc ? div_lo_q : rx_head;
         OFS_IEN:   bus_rdata = divacc ? div_hi_q : {6'b0, ien_q};
         OFS_IDENT: bus_rdata = ident;
         OFS_LCTL:  bus_rdata = lctl_q;
         OFS_LSTAT: bus_rdata = lstat;
         default:   bus_rdata = 8'h00;
      endcase
   end

   p_divacc_ien_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_IEN && divacc) |=> $stable(ien_q));
   p_divacc_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DATA && divacc && !tx_pop && !tx_clr) |=> $stable(tx_cnt));
   p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fctl_wr && bus_wdata[FCTL_RXCLR_BIT]) |=> (rx_cnt == '0));
   p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_clr) |=> ovr_q);
   p_txe_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !lstat[5]);

endmodule

// File: tb/tb_uart_regfifo_ctrl.sv
module tb_uart_regfifo_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_pop = 1'b0, tx_busy = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_push = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   uart_regfifo_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop), .tx_busy(tx_busy),
      .rx_data(rx_data), .rx_push(rx_push)
   );

   // {trigger code, bytes pushed, expected data-available interrupt}
   localparam logic [7:0] TRIG_VEC [8] = '{
      {2'd0, 5'd1,  1'b1}, {2'd1, 5'd3,  1'b0}, {2'd1, 5'd4,  1'b1},
      {2'd2, 5'd7,  1'b0}, {2'd2, 5'd8,  1'b1}, {2'd3, 5'd13, 1'b0},
      {2'd3, 5'd14, 1'b1}, {2'd0, 5'd0,  1'b0}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic push_rx(input logic [7:0] d);
      rx_data = d; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_tx();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      rd_chk("R3 reset line status", 3'd5, 8'h60);
      rd_chk("R8 reset ident", 3'd2, 8'h01);
      rd_chk("R2 reset line control", 3'd3, 8'h00);
      rd_chk("R2 reset int enable", 3'd1, 8'h00);
      chk("R9 reset irq", {7'b0, irq}, 8'h00);

      // Divisor access banking
      wr(3'd3, 8'h83);
      wr(3'd0, 8'h20);
      wr(3'd1, 8'h5A);
      rd_chk("R2 divisor low", 3'd0, 8'h20);
      rd_chk("R2 divisor high", 3'd1, 8'h5A);
      chk("R2 no tx push while banked", {7'b0, tx_valid}, 8'h00);
      wr(3'd1, 8'h02);
      wr(3'd3, 8'h03);
      rd_chk("R2 int enable untouched", 3'd1, 8'h00);
      rd_chk("R2 line control", 3'd3, 8'h03);

      // Enable queues, transmit-empty interrupt without priming
      wr(3'd2, 8'h07);
      wr(3'd1, 8'h02);
      rd_chk("R2 int enable written", 3'd1, 8'h02);
      chk("R4 no irq before priming", {7'b0, irq}, 8'h00);
      rd_chk("R6 status after 0x07", 3'd5, 8'h60);

      wr(3'd0, 8'h11);
      rd_chk("R3 empty flag clears on write", 3'd5, 8'h00);
      chk("R1 tx head", tx_data, 8'h11);
      rd_chk("R8 ident none queues on", 3'd2, 8'hC1);
      pop_tx();
      chk("R4 irq after drain", {7'b0, irq}, 8'h01);
      rd_chk("R8 ident transmit-empty", 3'd2, 8'hC2);
      rd_chk("R5 ident read cleared", 3'd2, 8'hC1);
      chk("R5 irq low after read", {7'b0, irq}, 8'h00);

      // Fill 17, one dropped, 16 drained in order
      for (int i = 0; i < 17; i++) wr(3'd0, 8'h20 + 8'(i));
      for (int i = 0; i < 16; i++) begin
         chk("R1 tx order", tx_data, 8'h20 + 8'(i));
         if (i == 8) chk("R4 no irq part drained", {7'b0, irq}, 8'h00);
         pop_tx();
      end
      chk("R1 17th byte dropped", {7'b0, tx_valid}, 8'h00);
      chk("R4 irq after full drain", {7'b0, irq}, 8'h01);
      wr(3'd0, 8'h55);
      chk("R5 write clears pending", {7'b0, irq}, 8'h00);
      pop_tx();

      // Trigger table
      wr(3'd1, 8'h01);
      for (int k = 0; k < 8; k++) begin
         wr(3'd2, {TRIG_VEC[k][7:6], 6'b000011});
         for (int n = 0; n < int'(TRIG_VEC[k][5:1]); n++) push_rx(8'(n));
         chk("R7 trigger irq", {7'b0, irq}, {7'b0, TRIG_VEC[k][0]});
         rd_chk("R8 trigger ident", 3'd2, TRIG_VEC[k][0] ? 8'hC4 : 8'hC1);
      end

      // Priority
      wr(3'd2, 8'h03);
      push_rx(8'hA5);
      wr(3'd1, 8'h03);
      rd_chk("R8 data-available first", 3'd2, 8'hC4);
      chk("R9 irq both causes", {7'b0, irq}, 8'h01);
      rd_chk("R12 data read", 3'd0, 8'hA5);
      rd_chk("R12 ready cleared", 3'd5, 8'h60);
      rd_chk("R8 transmit-empty next", 3'd2, 8'hC2);
      rd_chk("R8 nothing left", 3'd2, 8'hC1);
      chk("R9 irq low", {7'b0, irq}, 8'h00);

      // Overrun
      wr(3'd2, 8'h03);
      for (int i = 0; i < 17; i++) push_rx(8'h40 + 8'(i));
      rd_chk("R10 overrun set", 3'd5, 8'h63);
      rd_chk("R10 overrun cleared by read", 3'd5, 8'h61);
      for (int i = 0; i < 16; i++) rd_chk("R1 rx order", 3'd0, 8'h40 + 8'(i));
      rd_chk("R12 rx empty", 3'd5, 8'h60);

      tx_busy = 1'b1; #1;
      rd_chk("R3 shifter busy", 3'd5, 8'h20);
      tx_busy = 1'b0; #1;
      rd_chk("R3 shifter idle", 3'd5, 8'h60);

      // Queues disabled
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h71);
      wr(3'd0, 8'h72);
      chk("R11 single tx byte", tx_data, 8'h71);
      pop_tx();
      chk("R11 second tx dropped", {7'b0, tx_valid}, 8'h00);
      push_rx(8'h81);
      push_rx(8'h82);
      rd_chk("R11 single rx byte overrun", 3'd5, 8'h63);
      rd_chk("R11 rx kept first", 3'd0, 8'h81);
      rd_chk("R8 ident queues off", 3'd2, 8'h02);
      push_rx(8'h90);
      wr(3'd2, 8'h01);
      rd_chk("R11 enable change empties", 3'd5, 8'h60);

      // Reset bits self-clear
      wr(3'd2, 8'h07);
      push_rx(8'h91);
      rd_chk("R6 rx works after reset bits", 3'd5, 8'h61);
      rd_chk("R6 rx data", 3'd0, 8'h91);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule